// File: doc/BRIEF.md
# Receive Status and Interrupt Controller

This block holds the status flags of a multi-channel serial audio receiver and turns them into interrupt requests. A serializer elsewhere signals each arriving word with a one-cycle `word_ready` pulse, and `word_even` marks words that belong to an even-numbered time slot. Slot zero counts as even. The bus side reports a read of the status register with `stat_rd` and reads of the per-receiver data registers with `data_rd`. Three flags are kept: data-full, even-slot-data and overrun. Each one clears only after a defined sequence of reads.

Three interrupt requests come out of the flags: a data-with-exception request, an even-slot-data request and a plain data request. They are ranked, so at most one is raised at a time. A receiver-only reset input forces the status back to its power-on state at once and disconnects the receive data pins. The enable inputs keep their values through this reset.

A hard reset (`rst_n` low) brings the block to its idle state: all flags clear, the read-sequence state machine in `SEQ_IDLE`, and the pins connected. The sequence machine has two states. It goes from `SEQ_IDLE` to `SEQ_ARMED` on a status read while overrun is set. It stays in `SEQ_ARMED` on a further status read, which restarts the read collection. It returns to `SEQ_IDLE` once every enabled receiver has been read, and it also returns there on a receiver-only reset.

Top module: `rx_status_irq`

## Requirements
- R1: A `word_ready` pulse sets the data-full flag at the next edge. `irq_data` is high while `en_data` and data-full are set and no higher-ranked request is raised.
- R2: Data-full and even-slot-data clear at the edge where the data reads seen since the last word, counting the current cycle, cover every receiver whose `rx_en` bit is 1. Reads in the cycle of a `word_ready` are discarded. A new word in the completing cycle keeps data-full set. With `rx_en` all zero, reads never clear the flags.
- R3: A `word_ready` with `word_even` high sets even-slot-data. `irq_even` is high while `en_even` and even-slot-data are set and the exception request is not raised.
- R4: Overrun is set at the edge after a `word_ready` that arrives while data-full is already set, or after an `ovr_evt` pulse.
- R5: Overrun clears only when a status read made while overrun is set is followed, in later cycles, by data reads covering all enabled receivers. Data reads without that earlier status read leave it set. A new overrun in the completing cycle keeps it set.
- R6: `irq_exc` is high while `en_exc`, data-full and overrun are all set.
- R7: Ranking is `irq_exc` over `irq_even` over `irq_data`, and no two of them are high together.
- R8: While `rx_soft_rst` is high, all three requests are low in the same cycle, every flag is cleared at the next edge, and all events are ignored. The enable inputs take effect again as soon as it drops.
- R9: `pin_en` is 0 while `rx_soft_rst` is high and 1 otherwise.
- R10: After a hard reset, all requests are 0 and `pin_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| word_ready | input | 1 | One-cycle pulse: a received word is ready |
| word_even | input | 1 | Qualifies `word_ready`: the word is from an even slot |
| ovr_evt | input | 1 | One-cycle overrun pulse from the serializer |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | NUM_RX | Per-receiver data register read strobes |
| rx_en | input | NUM_RX | Receiver enable bits |
| en_exc | input | 1 | Enable for the exception request |
| en_even | input | 1 | Enable for the even-slot-data request |
| en_data | input | 1 | Enable for the plain data request |
| rx_soft_rst | input | 1 | Receiver-only reset control, active high |
| irq_exc | output | 1 | Data-with-exception interrupt request |
| irq_even | output | 1 | Even-slot-data interrupt request |
| irq_data | output | 1 | Plain data interrupt request |
| pin_en | output | 1 | Receive data pin connect, 0 = disconnected |

## Verification
Two events can fall in the same cycle. A new `word_ready` can arrive in the cycle whose data reads complete coverage, so setting and clearing data-full (and raising overrun) compete. An `ovr_evt` can arrive in the cycle that finishes the overrun clearing sequence. Directed steps line each of these up exactly, and a long random phase drives dense strobes that collide often. Every cycle, the outputs are compared against a behavioural model that applies set-over-clear priority, and this is what decides the outcome of each collision.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_t;

    typedef enum logic [1:0] {
        GRANT_NONE = 2'd0,
        GRANT_DATA = 2'd1,
        GRANT_EVEN = 2'd2,
        GRANT_EXC  = 2'd3
    } grant_t;
endpackage

// File: rtl/rxs_read_tracker.sv
module rxs_read_tracker #(
    parameter int NUM_RX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              restart,
    input  logic [NUM_RX-1:0] data_rd,
    input  logic [NUM_RX-1:0] rx_en,
    output logic              all_read
);
    logic [NUM_RX-1:0] seen_q;
    logic [NUM_RX-1:0] covered;

    for (genvar i = 0; i < NUM_RX; i++) begin : g_rx
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seen_q[i] <= 1'b0;
            end else if (clr || restart) begin
                seen_q[i] <= 1'b0;
            end else if (data_rd[i]) begin
                seen_q[i] <= 1'b1;
            end
        end
        assign covered[i] = !rx_en[i] || seen_q[i] || data_rd[i];
    end

    assign all_read = (|rx_en) && (&covered);
endmodule

// File: rtl/rxs_ovr_seq.sv
module rxs_ovr_seq
    import rxs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic ovr_set,
    input  logic stat_rd,
    input  logic seq_cov,
    output logic ovr_q,
    output logic armed
);
    seq_state_t state_q, state_d;
    logic       seq_done;

    assign seq_done = (state_q == SEQ_ARMED) && !stat_rd && seq_cov;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (stat_rd && ovr_q) state_d = SEQ_ARMED;
            end
            SEQ_ARMED: begin
                if (stat_rd)       state_d = SEQ_ARMED;
                else if (seq_cov)  state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            ovr_q   <= 1'b0;
        end else if (soft_rst) begin
            state_q <= SEQ_IDLE;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ovr_set)       ovr_q <= 1'b1;
            else if (seq_done) ovr_q <= 1'b0;
        end
    end

    assign armed = (state_q == SEQ_ARMED);
endmodule

// File: rtl/rxs_irq_arb.sv
module rxs_irq_arb
    import rxs_pkg::*;
(
    input  logic en_exc,
    input  logic en_even,
    input  logic en_data,
    input  logic full_q,
    input  logic even_q,
    input  logic ovr_q,
    input  logic mute,
    output logic irq_exc,
    output logic irq_even,
    output logic irq_data
);
    grant_t grant;

    always_comb begin
        if (mute)                             grant = GRANT_NONE;
        else if (en_exc && full_q && ovr_q)   grant = GRANT_EXC;
        else if (en_even && even_q)           grant = GRANT_EVEN;
        else if (en_data && full_q)           grant = GRANT_DATA;
        else                                  grant = GRANT_NONE;
    end

    always_comb begin
        irq_exc  = 1'b0;
        irq_even = 1'b0;
        irq_data = 1'b0;
        unique case (grant)
            GRANT_EXC:  irq_exc  = 1'b1;
            GRANT_EVEN: irq_even = 1'b1;
            GRANT_DATA: irq_data = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/rx_status_irq.sv
module rx_status_irq #(
    parameter int NUM_RX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_ready,
    input  logic              word_even,
    input  logic              ovr_evt,
    input  logic              stat_rd,
    input  logic [NUM_RX-1:0] data_rd,
    input  logic [NUM_RX-1:0] rx_en,
    input  logic              en_exc,
    input  logic              en_even,
    input  logic              en_data,
    input  logic              rx_soft_rst,
    output logic              irq_exc,
    output logic              irq_even,
    output logic              irq_data,
    output logic              pin_en
);
    logic full_q;
    logic even_q;
    logic ovr_q;
    logic armed;
    logic word_cov;
    logic seq_cov;
    logic ovr_set;
    logic word_in;

    assign word_in = word_ready && !rx_soft_rst;
    assign ovr_set = !rx_soft_rst && (ovr_evt || (word_ready && full_q));

    rxs_read_tracker #(.NUM_RX(NUM_RX)) u_word_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_soft_rst),
        .restart  (word_ready),
        .data_rd  (data_rd),
        .rx_en    (rx_en),
        .all_read (word_cov)
    );

    rxs_read_tracker #(.NUM_RX(NUM_RX)) u_seq_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_soft_rst),
        .restart  (stat_rd),
        .data_rd  (data_rd),
        .rx_en    (rx_en),
        .all_read (seq_cov)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            even_q <= 1'b0;
        end else if (rx_soft_rst) begin
            full_q <= 1'b0;
            even_q <= 1'b0;
        end else if (word_in) begin
            full_q <= 1'b1;
            even_q <= even_q || word_even;
        end else if (word_cov) begin
            full_q <= 1'b0;
            even_q <= 1'b0;
        end
    end

    rxs_ovr_seq u_ovr (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (rx_soft_rst),
        .ovr_set  (ovr_set),
        .stat_rd  (stat_rd),
        .seq_cov  (seq_cov),
        .ovr_q    (ovr_q),
        .armed    (armed)
    );

    rxs_irq_arb u_arb (
        .en_exc   (en_exc),
        .en_even  (en_even),
        .en_data  (en_data),
        .full_q   (full_q),
        .even_q   (even_q),
        .ovr_q    (ovr_q),
        .mute     (rx_soft_rst),
        .irq_exc  (irq_exc),
        .irq_even (irq_even),
        .irq_data (irq_data)
    );

    assign pin_en = !rx_soft_rst;
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker (
    input logic clk,
    input logic rst_n,
    input logic word_ready,
    input logic rx_soft_rst,
    input logic full_q,
    input logic ovr_q,
    input logic armed,
    input logic irq_exc,
    input logic irq_even,
    input logic irq_data,
    input logic pin_en
);
    assert_full_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready && !rx_soft_rst) |=> full_q);

    assert_ovr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready && full_q && !rx_soft_rst) |=> ovr_q);

    assert_ovr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !armed && !rx_soft_rst) |=> ovr_q);

    assert_rank_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_exc, irq_even, irq_data}));

    assert_soft_mute_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_soft_rst |-> !(irq_exc || irq_even || irq_data));

    assert_soft_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_soft_rst |=> !full_q && !ovr_q && !armed);

    assert_pins_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_soft_rst |-> !pin_en);
endmodule

bind rx_status_irq rxs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_ready  (word_ready),
    .rx_soft_rst (rx_soft_rst),
    .full_q      (full_q),
    .ovr_q       (ovr_q),
    .armed       (armed),
    .irq_exc     (irq_exc),
    .irq_even    (irq_even),
    .irq_data    (irq_data),
    .pin_en      (pin_en)
);

// File: tb/rx_status_irq_test.sv
`timescale 1ns/1ps
module rx_status_irq_test;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic word_ready = 0, word_even = 0, ovr_evt = 0, stat_rd = 0;
    logic [N-1:0] data_rd = '0, rx_en = '1;
    logic en_exc = 1, en_even = 1, en_data = 1, rx_soft_rst = 0;
    logic irq_exc, irq_even, irq_data, pin_en;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rx_status_irq #(.NUM_RX(N)) uut (
        .clk(clk), .rst_n(rst_n), .word_ready(word_ready), .word_even(word_even),
        .ovr_evt(ovr_evt), .stat_rd(stat_rd), .data_rd(data_rd), .rx_en(rx_en),
        .en_exc(en_exc), .en_even(en_even), .en_data(en_data),
        .rx_soft_rst(rx_soft_rst), .irq_exc(irq_exc), .irq_even(irq_even),
        .irq_data(irq_data), .pin_en(pin_en)
    );

    // behavioural reference state
    bit m_full, m_even, m_ovr, m_wait;
    bit m_got[N];
    bit m_seq[N];

    function automatic bit covers(bit got[N]);
        int need = 0;
        int have = 0;
        for (int i = 0; i < N; i++) begin
            if (rx_en[i]) begin
                need++;
                if (got[i] || data_rd[i]) have++;
            end
        end
        return (need > 0) && (have == need);
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            if (rx_soft_rst) begin
                m_full = 0; m_even = 0; m_ovr = 0; m_wait = 0;
                for (int i = 0; i < N; i++) begin m_got[i] = 0; m_seq[i] = 0; end
            end else begin
                bit wc, sc, oset;
                wc = covers(m_got);
                sc = m_wait && !stat_rd && covers(m_seq);
                oset = ovr_evt || (word_ready && m_full);
                if (word_ready) begin
                    m_full = 1; m_even = m_even || word_even;
                end else if (wc) begin
                    m_full = 0; m_even = 0;
                end
                for (int i = 0; i < N; i++) begin
                    m_got[i] = word_ready ? 1'b0 : (m_got[i] || data_rd[i]);
                    m_seq[i] = stat_rd ? 1'b0 : (m_seq[i] || data_rd[i]);
                end
                if (stat_rd && m_ovr) m_wait = 1;
                else if (sc) m_wait = 0;
                if (oset) m_ovr = 1;
                else if (sc) m_ovr = 0;
            end
        end
    end

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_exc, e_even, e_data;
            e_exc  = !rx_soft_rst && en_exc && m_full && m_ovr;
            e_even = !rx_soft_rst && !e_exc && en_even && m_even;
            e_data = !rx_soft_rst && !e_exc && !e_even && en_data && m_full;
            check("R6 irq_exc", irq_exc, e_exc);
            check("R3 irq_even", irq_even, e_even);
            check("R1 irq_data", irq_data, e_data);
            check("R9 pin_en", pin_en, !rx_soft_rst);
            check("R7 onehot", ($countones({irq_exc, irq_even, irq_data}) <= 1), 1'b1);
        end
    end

    task automatic nxt();
        @(posedge clk);
        #1;
        word_ready = 0; word_even = 0; ovr_evt = 0; stat_rd = 0; data_rd = '0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        check("R10 reset irq_exc", irq_exc, 0);
        check("R10 reset irq_even", irq_even, 0);
        check("R10 reset irq_data", irq_data, 0);
        check("R10 reset pin_en", pin_en, 1);
        nxt();

        // R1 / R2: full set, partial reads keep it, last read clears
        word_ready = 1; nxt();
        check("R1 data after word", irq_data, 1);
        data_rd = 4'b0111; nxt();
        check("R2 partial reads keep", irq_data, 1);
        data_rd = 4'b1000; nxt();
        check("R2 all read clears", irq_data, 0);

        // R2: subset of receivers enabled, one-cycle read
        rx_en = 4'b0101; word_ready = 1; nxt();
        data_rd = 4'b0101; nxt();
        check("R2 subset cleared", irq_data, 0);

        // R2: no receiver enabled, reads never clear
        rx_en = 4'b0000; word_ready = 1; nxt();
        data_rd = 4'b1111; nxt();
        check("R2 none enabled holds", irq_data, 1);
        rx_en = 4'b1111; data_rd = 4'b1111; nxt();
        check("R2 cleared after enable", irq_data, 0);

        // R3: even slot word
        word_ready = 1; word_even = 1; nxt();
        check("R3 even raised", irq_even, 1);
        check("R7 even over data", irq_data, 0);
        data_rd = 4'b1111; nxt();
        check("R3 even cleared", irq_even, 0);

        // R4 / R6 / R5: overrun and its clearing sequence
        word_ready = 1; nxt();
        word_ready = 1; nxt();
        check("R4 R6 exception", irq_exc, 1);
        data_rd = 4'b1111; nxt();
        check("R6 exc needs full", irq_exc, 0);
        word_ready = 1; nxt();
        check("R5 overrun held without status read", irq_exc, 1);
        stat_rd = 1; nxt();
        data_rd = 4'b1111; nxt();
        check("R5 sequence clears full", irq_exc, 0);
        word_ready = 1; nxt();
        check("R5 overrun cleared", irq_exc, 0);
        check("R5 data only", irq_data, 1);
        data_rd = 4'b1111; nxt();

        // R5: overrun event in the completing cycle keeps it
        ovr_evt = 1; word_ready = 1; nxt();
        stat_rd = 1; nxt();
        data_rd = 4'b1111; ovr_evt = 1; nxt();
        word_ready = 1; nxt();
        check("R5 set wins over clear", irq_exc, 1);
        stat_rd = 1; nxt();
        data_rd = 4'b1111; nxt();

        // R7: ranking with both even and overrun present
        word_ready = 1; word_even = 1; nxt();
        word_ready = 1; nxt();
        check("R7 exc over even", irq_exc, 1);
        check("R7 even suppressed", irq_even, 0);
        en_exc = 0; #1;
        check("R7 even when exc off", irq_even, 1);
        en_exc = 1; #1;

        // R8 / R9: receiver-only reset
        rx_soft_rst = 1; #1;
        check("R8 soft mutes exc", irq_exc, 0);
        check("R9 pins off", pin_en, 0);
        word_ready = 1; ovr_evt = 1; nxt();
        rx_soft_rst = 0; #1;
        check("R8 flags cleared", irq_even | irq_exc | irq_data, 0);
        check("R9 pins back", pin_en, 1);
        word_ready = 1; nxt();
        check("R8 enables kept", irq_data, 1);
        check("R8 overrun cleared", irq_exc, 0);
        data_rd = 4'b1111; nxt();

        // random phase, compared every cycle to the model
        for (int c = 0; c < 4000; c++) begin
            word_ready  = ($urandom % 4) == 0;
            word_even   = $urandom % 2;
            ovr_evt     = ($urandom % 40) == 0;
            stat_rd     = ($urandom % 6) == 0;
            data_rd     = ($urandom % 3 == 0) ? N'($urandom) : '0;
            rx_soft_rst = ($urandom % 80) == 0;
            if (c % 64 == 0) begin
                rx_en   = N'($urandom);
                en_exc  = $urandom % 2;
                en_even = $urandom % 2;
                en_data = $urandom % 2;
            end
            @(posedge clk);
            #1;
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule